// File: doc/BRIEF.md
# Dual Wiper Serial Position Loader

This block is a write-only serial slave that sets the tap positions of two independent 256-step resistor ladders. A host lowers the select line and clocks bits in on the data line. Each rising serial-clock edge seen while select is low shifts one bit into a capture register. When select returns high, the most recent nine bits are read as a frame: the first of them is a register address and the other eight are the new position, sent most significant bit first. The frame is written into the addressed position register, and that register drives its 8-bit wiper output at once.

The serial clock, select and data pins are brought into a faster system clock through synchronizer chains. Their edges are found in that domain, so every register in the block runs on one clock. Each position register has a one-cycle update strobe, which marks exactly when a new value lands. A position of 0x00 means the tap nearest the low end of the ladder and 0xFF the tap nearest the high end. Reset places both wipers at midscale.

Top module: `dual_wiper_loader`

## Requirements
- R1: A bit is captured only on a rising serial-clock edge that occurs while select is low. Serial-clock edges while select is high change neither wiper output.
- R2: A frame is nine bits in order: address, then position bits 7 down to 0. The position value, including the end values 0x00 (low end) and 0xFF (high end), appears unchanged on the addressed wiper output.
- R3: When more than nine bits are clocked during one low period of select, only the final nine are used.
- R4: The frame is committed on the rising edge of select. The update strobe rises SYNC_STAGES+1 system-clock cycles after the select pin rises (3 with defaults), and in that same cycle the wiper output holds the new value.
- R5: Address bit 0 writes wiper A and address bit 1 writes wiper B. The register that is not addressed keeps its value.
- R6: Synchronous active-high reset sets both wiper outputs to 0x80 and clears both strobes.
- R7: A select low period with fewer than nine captured bits is discarded: no strobe is raised and neither wiper changes.
- R8: Each strobe is high for exactly one cycle per commit, the two strobes are never high together, and a wiper output changes only in a cycle where its strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_n_i | input | 1 | Active-low select; its rising edge commits the frame |
| din_i | input | 1 | Serial data, address bit first, then position MSB first |
| wiper_a_o | output | 8 | Tap position of wiper A |
| wiper_b_o | output | 8 | Tap position of wiper B |
| upd_a_o | output | 1 | One-cycle pulse when wiper A is written |
| upd_b_o | output | 1 | One-cycle pulse when wiper B is written |

## Verification
The assertions assume the serial pins change slowly compared with the system clock. Each level must stay stable for more than SYNC_STAGES+1 system cycles, so that every edge is seen once and the data line is settled when its sampling clock edge goes through the synchronizers. They also assume a serial-clock rise and a select rise never arrive in the same system cycle. The stimulus holds every serial half-period and every select setup and hold for four system cycles. Data changes only while the serial clock is low, and select is raised only after the serial clock has been low for several cycles.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int WIPER_W     = 8;
    localparam int N_WIPERS    = 2;
    localparam int ADDR_W      = (N_WIPERS > 1) ? $clog2(N_WIPERS) : 1;
    localparam int FRAME_BITS  = ADDR_W + WIPER_W;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1);
    localparam int SYNC_STAGES = 2;

    typedef logic [WIPER_W-1:0] pos_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        pos_t              pos;
    } frame_t;

    // Pin indices inside the synchronized bundle
    typedef enum int {
        PIN_SCLK = 0,
        PIN_CSN  = 1,
        PIN_DIN  = 2
    } pin_e;

    localparam int N_PINS = 3;

    function automatic pos_t midscale();
        pos_t m;
        m = '0;
        m[WIPER_W-1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/wl_sync.sv
module wl_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= RESET_VAL;
                    else     chain_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= RESET_VAL;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/wl_edge.sv
module wl_edge #(
    parameter int               WIDTH     = 3,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RESET_VAL;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/wl_shift.sv
module wl_shift
    import wiper_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_active_i,
    input  logic   sclk_rise_i,
    input  logic   din_i,
    output frame_t frame_o,
    output logic   full_o
);

    logic [FRAME_BITS-1:0] sr_q;
    logic [CNT_W-1:0]      cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (!sel_active_i) begin
            cnt_q <= '0;
        end else if (sclk_rise_i) begin
            sr_q <= {sr_q[FRAME_BITS-2:0], din_i};
            if (cnt_q != CNT_W'(FRAME_BITS))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign frame_o = frame_t'(sr_q);
    assign full_o  = (cnt_q == CNT_W'(FRAME_BITS));

    // R3: the bit count saturates at one frame length
    a_r3_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(FRAME_BITS));

    // R1: while select is high the capture count stays clear
    a_r1_idle_clears: assert property (@(posedge clk) disable iff (rst)
        !sel_active_i |=> cnt_q == '0);

endmodule

// File: rtl/wl_bank.sv
module wl_bank
    import wiper_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           commit_i,
    input  logic                           full_i,
    input  frame_t                         frame_i,
    output logic [N_WIPERS-1:0][WIPER_W-1:0] wiper_o,
    output logic [N_WIPERS-1:0]            upd_o
);

    generate
        for (genvar i = 0; i < N_WIPERS; i++) begin : g_wiper
            logic hit;
            assign hit = commit_i && full_i && (frame_i.addr == ADDR_W'(i));

            always_ff @(posedge clk) begin
                if (rst) begin
                    wiper_o[i] <= midscale();
                    upd_o[i]   <= 1'b0;
                end else begin
                    upd_o[i] <= hit;
                    if (hit) wiper_o[i] <= frame_i.pos;
                end
            end

            // R8: a wiper moves only together with its strobe
            a_r8_move_needs_strobe: assert property (@(posedge clk) disable iff (rst)
                !upd_o[i] |-> $stable(wiper_o[i]));

            // R8: strobe lasts one cycle per commit
            a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
                upd_o[i] |=> !upd_o[i]);

            // R6: out of reset each wiper sits at midscale
            a_r6_reset_midscale: assert property (@(posedge clk)
                $past(rst) |-> (wiper_o[i] == midscale() && !upd_o[i]));
        end
    endgenerate

    // R8: never two strobes at once
    a_r8_onehot_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_o));

    // R7: a strobe follows only a commit of a complete frame
    a_r7_full_frame_only: assert property (@(posedge clk) disable iff (rst)
        (|upd_o) |-> ($past(full_i) && $past(commit_i)));

endmodule

// File: rtl/dual_wiper_loader.sv
module dual_wiper_loader
    import wiper_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk_i,
    input  logic         cs_n_i,
    input  logic         din_i,
    output logic [7:0]   wiper_a_o,
    output logic [7:0]   wiper_b_o,
    output logic         upd_a_o,
    output logic         upd_b_o
);

    localparam logic [N_PINS-1:0] PIN_IDLE = N_PINS'(1) << PIN_CSN;

    logic [N_PINS-1:0] pins_raw;
    logic [N_PINS-1:0] pins_s;
    logic [N_PINS-1:0] pins_rise;
    logic [N_PINS-1:0] pins_fall;

    frame_t                           frame;
    logic                             full;
    logic [N_WIPERS-1:0][WIPER_W-1:0] wipers;
    logic [N_WIPERS-1:0]              upd;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCLK] = sclk_i;
        pins_raw[PIN_CSN]  = cs_n_i;
        pins_raw[PIN_DIN]  = din_i;
    end

    wl_sync #(
        .WIDTH     (N_PINS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    wl_edge #(
        .WIDTH     (N_PINS),
        .RESET_VAL (PIN_IDLE)
    ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (pins_s),
        .rise_o  (pins_rise),
        .fall_o  (pins_fall)
    );

    wl_shift u_shift (
        .clk          (clk),
        .rst          (rst),
        .sel_active_i (!pins_s[PIN_CSN]),
        .sclk_rise_i  (pins_rise[PIN_SCLK]),
        .din_i        (pins_s[PIN_DIN]),
        .frame_o      (frame),
        .full_o       (full)
    );

    wl_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .commit_i (pins_rise[PIN_CSN]),
        .full_i   (full),
        .frame_i  (frame),
        .wiper_o  (wipers),
        .upd_o    (upd)
    );

    assign wiper_a_o = wipers[0];
    assign wiper_b_o = wipers[1];
    assign upd_a_o   = upd[0];
    assign upd_b_o   = upd[1];

    // R4: a commit strobe appears only right after select was seen rising
    a_r4_commit_on_release: assert property (@(posedge clk) disable iff (rst)
        (upd_a_o || upd_b_o) |-> $past(pins_rise[PIN_CSN]));

    // R1: a select falling edge never causes a strobe in the next cycle
    a_r1_no_strobe_on_select: assert property (@(posedge clk) disable iff (rst)
        pins_fall[PIN_CSN] |=> !(upd_a_o || upd_b_o));

endmodule

// File: tb/dual_wiper_loader_bench.sv
module dual_wiper_loader_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;
    logic [7:0] wa, wb;
    logic ua, ub;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit         sel;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sb[$];
    logic [7:0] model_a = 8'h80;
    logic [7:0] model_b = 8'h80;

    always #2 clk = ~clk;

    dual_wiper_loader u_dual_wiper_loader (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .din_i     (din),
        .wiper_a_o (wa),
        .wiper_b_o (wb),
        .upd_a_o   (ua),
        .upd_b_o   (ub)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && (ua || ub)) begin
            if (sb.size() == 0) begin
                check(0, "R8", "unexpected strobe", {30'd0, ub, ua}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(ub == e.sel && ua == !e.sel, e.req, "strobe select",
                      {30'd0, ub, ua}, e.sel ? 32'd2 : 32'd1);
                check((e.sel ? wb : wa) == e.val, e.req, "wiper value on strobe",
                      e.sel ? wb : wa, e.val);
            end
        end
    end

    task automatic serial_bit(input logic b);
        @(negedge clk) din = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    // Sends n bits MSB first from bits[n-1:0]; commit expected when n >= 9
    task automatic frame(input int n, input logic [31:0] bits, input string req);
        bit commit;
        logic [8:0] last9;
        commit = (n >= 9);
        last9  = bits[8:0];
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) serial_bit(bits[i]);
        repeat (4) @(negedge clk);
        if (commit) begin
            exp_t e;
            e.sel = last9[8];
            e.val = last9[7:0];
            e.req = req;
            sb.push_back(e);
            if (last9[8]) model_b = last9[7:0];
            else          model_a = last9[7:0];
        end
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!ua && !ub, "R4", "strobe too early", {30'd0, ub, ua}, 32'd0);
        @(negedge clk);
        check((ua || ub) == commit, commit ? "R4" : "R7", "strobe at latency",
              {30'd0, ub, ua}, {31'd0, commit});
        @(negedge clk);
        check(!ua && !ub, "R8", "strobe one cycle", {30'd0, ub, ua}, 32'd0);
        repeat (4) @(negedge clk);
        check(wa == model_a, req, "wiper A after frame", wa, model_a);
        check(wb == model_b, req, "wiper B after frame", wb, model_b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R8", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6 reset state
        check(wa == 8'h80, "R6", "wiper A reset", wa, 8'h80);
        check(wb == 8'h80, "R6", "wiper B reset", wb, 8'h80);
        check(!ua && !ub, "R6", "strobes reset", {30'd0, ub, ua}, 0);

        // R1: serial clocks with select high are ignored
        for (int k = 0; k < 5; k++) serial_bit(k[0]);
        repeat (6) @(negedge clk);
        check(wa == 8'h80 && wb == 8'h80, "R1", "idle clocks", {wb, wa}, 16'h8080);

        // R2/R5: writes with address decode
        frame(9, {23'd0, 1'b0, 8'h3C}, "R5");
        frame(9, {23'd0, 1'b1, 8'hFF}, "R2");
        frame(9, {23'd0, 1'b0, 8'h00}, "R2");
        frame(9, {23'd0, 1'b1, 8'h96}, "R5");

        // R3: overlong frames keep the last nine bits
        frame(12, {20'd0, 3'b010, 1'b1, 8'hA5}, "R3");
        frame(16, {16'd0, 7'b1111111, 1'b0, 8'h5A}, "R3");

        // R7: short frames are dropped
        frame(8, {24'd0, 8'hC3}, "R7");
        frame(0, 32'd0, "R7");

        // R1: frame after idle clocks still decodes
        for (int k = 0; k < 3; k++) serial_bit(1'b1);
        frame(9, {23'd0, 1'b0, 8'h81}, "R1");

        // R6: reset mid-run restores midscale
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_a = 8'h80;
        model_b = 8'h80;
        @(negedge clk);
        check(wa == 8'h80 && wb == 8'h80, "R6", "reset mid-run", {wb, wa}, 16'h8080);

        frame(9, {23'd0, 1'b1, 8'h01}, "R5");
        check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
        finish_up();
    end

endmodule